// File: doc/BRIEF.md
# Shutdown and Wake-Up Controller

This block owns the main supply-enable line of a chip that can power itself down. It runs from the always-on 32.768 kHz slow clock. Software programs it through a small 32-bit register bus. A shutdown request is accepted only when the write carries the correct key byte. Once the supply is off, the block watches a set of wake pins and two alarm lines, one from the real-time clock and one from the real-time timer. The first source that is enabled and qualified turns the supply back on.

Each wake pin has its own enable bit and its own active-level bit. All pins share one debounce length, picked from a fixed table of slow-clock counts. A pin qualifies only after it has been seen at its active level on that many consecutive slow-clock edges while the supply is off. Alarm lines are not debounced. The status register records which sources caused the wake-up and clears when it is read. A status of zero therefore means that the last start was a plain power-on.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, pwr_en is 1, and the mode, wake-input and status registers all read as zero.
- R2: A write to offset 0x00 with bits 31:24 equal to 0xA5 and bit 0 set drives pwr_en low after the clock edge that accepts the write. Bits 23:1 of that write have no effect.
- R3: A write to offset 0x00 has no effect on pwr_en if bits 31:24 are not 0xA5 or if bit 0 is clear.
- R4: Offset 0x04 (mode) keeps the debounce code in bits 26:24, the timer-alarm enable in bit 16 and the clock-alarm enable in bit 17, and all other bits read as zero. Offset 0x0C (wake inputs) keeps the pin enables in bits 15:0 and the pin active levels in bits 31:16, and all of these bits read back as written.
- R5: Debounce codes 0, 1, 2, 3, 4 and 5 require 0, 3, 32, 512, 4096 and 32768 consecutive active samples, and codes 6 and 7 act as code 5. Samples are taken only while the supply is off. The wake happens at the N-th consecutive active edge, or at the first edge for code 0. One inactive sample restarts the count.
- R6: A level bit of 1 makes a pin active high and a level bit of 0 makes it active low. A pin whose enable bit is 0 never causes a wake.
- R7: While the supply is off, the clock alarm (enabled by mode bit 17) wakes the block at the next edge and sets status bit 5. The timer alarm (enabled by mode bit 16) does the same and sets status bit 4. Neither alarm is debounced.
- R8: A wake sets pwr_en and the status bits of every source that qualifies at the same edge. Sources that become active while pwr_en is 1 have no effect on pwr_en or on the status.
- R9: Status at offset 0x08 holds one flag per wake pin in bits 31:16, plus bits 5 and 4. A read returns the current flags and clears them at the edge that ends the read.
- R10: After zero has been written to both the mode and the wake-input registers, no pin and no alarm can wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| wake_pin | input | 16 | Wake-up pins |
| rtc_alarm | input | 1 | Real-time-clock alarm |
| rtt_alarm | input | 1 | Real-time-timer alarm |
| pwr_en | output | 1 | Main supply enable |

## Verification
The hardest cases to reach are the debounce boundaries. A wake must come at exactly the N-th consecutive active edge after shutdown, and not one edge earlier. To get there, the stimulus holds a pin at its active level from before the shutdown write, so that the count starts at the first edge with the supply off. It then samples pwr_en after N-1 edges and again after N edges. One pass uses a one-edge glitch to show that the count restarts. Another uses reserved code 7 to cover the full 32768-edge window.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
   localparam logic [7:0] CMD_KEY   = 8'hA5;
   localparam int         OFS_CTRL  = 0;
   localparam int         OFS_MODE  = 4;
   localparam int         OFS_STAT  = 8;
   localparam int         OFS_WIN   = 12;
   localparam int         MAX_PINS  = 16;
   localparam int         DBC_MAX   = 32768;
   localparam int         STAT_RTC  = 5;
   localparam int         STAT_RTT  = 4;

   typedef struct packed {
      logic [2:0] dbc;
      logic       rtc_en;
      logic       rtt_en;
   } mode_t;

   // consecutive active samples needed per debounce code
   function automatic int unsigned dbc_cycles(input logic [2:0] code);
      case (code)
         3'd0:    return 0;
         3'd1:    return 3;
         3'd2:    return 32;
         3'd3:    return 512;
         3'd4:    return 4096;
         default: return DBC_MAX;
      endcase
   endfunction
endpackage

// File: rtl/pwr_wake_regs.sv
module pwr_wake_regs
   import pwr_wake_pkg::*;
#(
   parameter int NPINS   = 16,
   parameter int ADDR_W  = 4,
   parameter bit HAS_RTT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [31:0]       status_in,
   output mode_t             mode_o,
   output logic [NPINS-1:0]  pin_en_o,
   output logic [NPINS-1:0]  pin_lvl_o,
   output logic              shdn_req_o,
   output logic              status_clr_o
);
   logic sel_ctrl, sel_mode, sel_stat, sel_win;
   logic [31:0] rd_mode, rd_win;

   assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_mode = (bus_addr == ADDR_W'(OFS_MODE));
   assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign sel_win  = (bus_addr == ADDR_W'(OFS_WIN));

   assign shdn_req_o   = bus_wr && sel_ctrl && (bus_wdata[31:24] == CMD_KEY) && bus_wdata[0];
   assign status_clr_o = bus_rd && sel_stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o    <= '0;
         pin_en_o  <= '0;
         pin_lvl_o <= '0;
      end else begin
         if (bus_wr && sel_mode) begin
            mode_o.dbc    <= bus_wdata[26:24];
            mode_o.rtc_en <= bus_wdata[17];
            mode_o.rtt_en <= HAS_RTT ? bus_wdata[16] : 1'b0;
         end
         if (bus_wr && sel_win) begin
            pin_en_o  <= bus_wdata[NPINS-1:0];
            pin_lvl_o <= bus_wdata[16+NPINS-1:16];
         end
      end
   end

   always_comb begin
      rd_mode         = '0;
      rd_mode[26:24]  = mode_o.dbc;
      rd_mode[17]     = mode_o.rtc_en;
      rd_mode[16]     = mode_o.rtt_en;
      rd_win          = '0;
      rd_win[NPINS-1:0]        = pin_en_o;
      rd_win[16+NPINS-1:16]    = pin_lvl_o;
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_mode)      bus_rdata = rd_mode;
         else if (sel_stat) bus_rdata = status_in;
         else if (sel_win)  bus_rdata = rd_win;
      end
   end

   // R4
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(mode_o) && $stable(pin_en_o) && $stable(pin_lvl_o));
endmodule

// File: rtl/pwr_wake_dbnc.sv
module pwr_wake_dbnc #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             level_in,
   input  logic             lvl_sel,
   input  logic [CNT_W-1:0] thr_m1,
   output logic             qual_o
);
   logic [CNT_W-1:0] cnt;
   logic             active;

   assign active = (level_in == lvl_sel);
   assign qual_o = run && active && (cnt >= thr_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || !active) cnt <= '0;
      else if (cnt != '1)      cnt <= cnt + 1'b1;
   end

   // R5
   dbnc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
   // R5
   dbnc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !active) |=> (cnt == '0));
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
   import pwr_wake_pkg::*;
#(
   parameter int NPINS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shdn_req,
   input  logic [NPINS-1:0] pin_qual,
   input  logic             rtc_hit,
   input  logic             rtt_hit,
   input  logic             status_clr,
   output logic             pwr_en,
   output logic [31:0]      status
);
   logic [NPINS-1:0] pin_flag;
   logic             rtc_flag, rtt_flag;
   logic             any_src, wake;

   assign any_src = (|pin_qual) || rtc_hit || rtt_hit;
   assign wake    = !pwr_en && any_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_en   <= 1'b1;
         pin_flag <= '0;
         rtc_flag <= 1'b0;
         rtt_flag <= 1'b0;
      end else begin
         if (wake)                  pwr_en <= 1'b1;
         else if (pwr_en && shdn_req) pwr_en <= 1'b0;
         if (wake) begin
            pin_flag <= (status_clr ? '0   : pin_flag) | pin_qual;
            rtc_flag <= (status_clr ? 1'b0 : rtc_flag) | rtc_hit;
            rtt_flag <= (status_clr ? 1'b0 : rtt_flag) | rtt_hit;
         end else if (status_clr) begin
            pin_flag <= '0;
            rtc_flag <= 1'b0;
            rtt_flag <= 1'b0;
         end
      end
   end

   always_comb begin
      status                   = '0;
      status[16+NPINS-1:16]    = pin_flag;
      status[STAT_RTC]         = rtc_flag;
      status[STAT_RTT]         = rtt_flag;
   end

   // R2
   shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_req && pwr_en) |=> !pwr_en);
   // R8
   wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> (status != '0));
   // R8
   on_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && !status_clr) |=> $stable(status));
   // R9
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_clr && pwr_en) |=> (status == '0));
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
   import pwr_wake_pkg::*;
#(
   parameter int NPINS   = 16,
   parameter int ADDR_W  = 4,
   parameter bit HAS_RTT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  wake_pin,
   input  logic              rtc_alarm,
   input  logic              rtt_alarm,
   output logic              pwr_en
);
   localparam int CNT_W = $clog2(DBC_MAX + 1);

   generate
      if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_pins
         $error("NPINS must be between 1 and 16");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must be at least 4");
      end
   endgenerate

   mode_t            mode;
   logic [NPINS-1:0] pin_en, pin_lvl, pin_qual;
   logic             shdn_req, status_clr, rtc_hit, rtt_hit;
   logic [31:0]      status;
   logic [CNT_W-1:0] thr_m1;
   int unsigned      thr;

   pwr_wake_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .HAS_RTT(HAS_RTT)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .status_in(status), .mode_o(mode), .pin_en_o(pin_en), .pin_lvl_o(pin_lvl),
      .shdn_req_o(shdn_req), .status_clr_o(status_clr)
   );

   always_comb begin
      thr    = dbc_cycles(mode.dbc);
      thr_m1 = (thr == 0) ? '0 : CNT_W'(thr - 1);
   end

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         pwr_wake_dbnc #(.CNT_W(CNT_W)) u_dbnc (
            .clk(clk), .rst_n(rst_n), .run(!pwr_en && pin_en[i]),
            .level_in(wake_pin[i]), .lvl_sel(pin_lvl[i]),
            .thr_m1(thr_m1), .qual_o(pin_qual[i])
         );
      end
      if (HAS_RTT) begin : g_rtt
         assign rtt_hit = mode.rtt_en && rtt_alarm;
      end else begin : g_no_rtt
         assign rtt_hit = 1'b0;
      end
   endgenerate

   assign rtc_hit = mode.rtc_en && rtc_alarm;

   pwr_wake_seq #(.NPINS(NPINS)) u_seq (
      .clk(clk), .rst_n(rst_n), .shdn_req(shdn_req), .pin_qual(pin_qual),
      .rtc_hit(rtc_hit), .rtt_hit(rtt_hit), .status_clr(status_clr),
      .pwr_en(pwr_en), .status(status)
   );

   // R3
   badkey_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[31:24] != CMD_KEY && pwr_en) |=> pwr_en);
endmodule

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] wake_pin = 16'hFFFF;
   logic        rtc_alarm = 1'b0, rtt_alarm = 1'b0;
   logic        pwr_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct { logic [31:0] exp; string tag; } item_t;
   item_t rdq[$];

   always #2 clk = ~clk;

   pwr_wake_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wake_pin(wake_pin), .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm),
      .pwr_en(pwr_en)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares each read against the scoreboard queue
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (bus_rd) begin
            if (rdq.size() == 0) begin
               checks++; errors++;
               $display("FAIL unexpected read actual=%h expected=none", bus_rdata);
            end else begin
               item_t it;
               it = rdq.pop_front();
               check(it.tag, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
      item_t it;
      it.exp = exp; it.tag = tag;
      rdq.push_back(it);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic shutdown();
      wr(4'h0, 32'hA500_0001);
      check("R2 shutdown", {31'd0, pwr_en}, 32'd0);
   endtask

   // pin held active from before shutdown: expect wake at edge n
   task automatic debounce_window(int n, string tag);
      shutdown();
      for (int k = 1; k < n; k++) @(negedge clk);
      check({tag, " one edge early"}, {31'd0, pwr_en}, 32'd0);
      @(negedge clk);
      check({tag, " at window"}, {31'd0, pwr_en}, 32'd1);
   endtask

   initial begin
      do_reset();
      // R1 reset state
      check("R1 pwr_en", {31'd0, pwr_en}, 32'd1);
      rd(4'h4, 32'h0, "R1 mode");
      rd(4'h8, 32'h0, "R1 status");
      rd(4'hC, 32'h0, "R1 win");

      // R4 readback
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'h4, 32'h0703_0000, "R4 mode readback");
      wr(4'hC, 32'h1234_ABCD);
      rd(4'hC, 32'h1234_ABCD, "R4 win readback");

      // R3 wrong key and missing command bit
      wr(4'h0, 32'h5A00_0001);
      check("R3 bad key", {31'd0, pwr_en}, 32'd1);
      wr(4'h0, 32'hA5FF_FFFE);
      check("R3 bit0 clear", {31'd0, pwr_en}, 32'd1);

      // R8 alarm while on is ignored
      wr(4'hC, 32'h0);
      wr(4'h4, 32'h0002_0000);
      @(negedge clk); rtc_alarm = 1'b1;
      @(negedge clk); rtc_alarm = 1'b0;
      rd(4'h8, 32'h0, "R8 alarm while on");

      // R7 clock alarm wake, R9 clear on read
      wr(4'h0, 32'hA512_3457);  // R2 don't-care bits set
      check("R2 dont-care bits", {31'd0, pwr_en}, 32'd0);
      repeat (5) @(negedge clk);
      check("R7 stays off", {31'd0, pwr_en}, 32'd0);
      rtc_alarm = 1'b1;
      @(negedge clk); rtc_alarm = 1'b0;
      check("R7 rtc wake", {31'd0, pwr_en}, 32'd1);
      rd(4'h8, 32'h0000_0020, "R7 rtc status");
      rd(4'h8, 32'h0, "R9 cleared");

      // R7 timer alarm; clock alarm disabled is ignored
      wr(4'h4, 32'h0001_0000);
      shutdown();
      @(negedge clk); rtc_alarm = 1'b1;
      @(negedge clk); rtc_alarm = 1'b0;
      check("R7 disabled rtc", {31'd0, pwr_en}, 32'd0);
      rtt_alarm = 1'b1;
      @(negedge clk); rtt_alarm = 1'b0;
      check("R7 rtt wake", {31'd0, pwr_en}, 32'd1);
      rd(4'h8, 32'h0000_0010, "R7 rtt status");

      // R6 active-low pin 3, code 0; pin 5 disabled
      wr(4'h4, 32'h0);
      wr(4'hC, 32'h0000_0008);
      wake_pin[5] = 1'b0;
      shutdown();
      repeat (10) @(negedge clk);
      check("R6 disabled pin", {31'd0, pwr_en}, 32'd0);
      wake_pin[3] = 1'b0;
      @(negedge clk);
      check("R6 R5 code0 wake", {31'd0, pwr_en}, 32'd1);
      rd(4'h8, 32'h0008_0000, "R9 pin3 flag");
      wake_pin = 16'hFFFF;

      // R5 code 1 on active-high pin 10
      wr(4'hC, 32'h0400_0400);
      wr(4'h4, 32'h0100_0000);
      debounce_window(3, "R5 code1");
      rd(4'h8, 32'h0400_0000, "R9 pin10 flag");

      // R5 code 2 with a glitch restart
      wr(4'h4, 32'h0200_0000);
      wake_pin[10] = 1'b0;
      shutdown();
      wake_pin[10] = 1'b1;
      repeat (20) @(negedge clk);
      wake_pin[10] = 1'b0;
      @(negedge clk);
      wake_pin[10] = 1'b1;
      repeat (31) @(negedge clk);
      check("R5 glitch restart", {31'd0, pwr_en}, 32'd0);
      @(negedge clk);
      check("R5 code2 after restart", {31'd0, pwr_en}, 32'd1);
      rd(4'h8, 32'h0400_0000, "R5 code2 flag");

      // R5 reserved code 7 acts as 32768
      wr(4'h4, 32'h0700_0000);
      debounce_window(32768, "R5 code7");

      // R10 all zero disables every source
      wr(4'h4, 32'h0003_0000);
      wr(4'hC, 32'h0000_0008);
      wr(4'h4, 32'h0);
      wr(4'hC, 32'h0);
      shutdown();
      wake_pin = 16'h0000;
      rtc_alarm = 1'b1; rtt_alarm = 1'b1;
      repeat (40) @(negedge clk);
      check("R10 no wake", {31'd0, pwr_en}, 32'd0);
      rtc_alarm = 1'b0; rtt_alarm = 1'b0;
      wake_pin = 16'hFFFF;
      do_reset();
      check("R1 after reset", {31'd0, pwr_en}, 32'd1);
      rd(4'h8, 32'h0, "R1 status after reset");

      repeat (3) @(negedge clk);
      if (rdq.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard left=%0d expected=0", rdq.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule